// File: doc/BRIEF.md
# VBUS Power Control and Fault Reporter

This block sits on the transceiver side of a USB OTG link. It turns the supply-select bits that the link has programmed into two power enables. One enables the on-chip charge pump. The other pulls the external 5 V switch line low. The switch line is active-low and open-drain, so the block drives it as an output-enable: when the enable is high the pad pulls low, and otherwise the line is released.

The block also watches an asynchronous digital fault line that comes from an external VBUS supervisor. It watches this line only when two separate enable bits are both set. While watching, the block reports the synchronized fault level as the VBUS-valid status bit. Each change of that level raises a request to send a status byte, and the request stays up until the bus side acknowledges it. When watching is off, the VBUS-valid bit comes from the internal comparator, and changes on the fault line raise no request.

Top module: `vbus_pwr_ctl`

## Requirements
- R1: One clock edge after `drv_int`=0 and `drv_ext`=0 are sampled, `pump_en` is 0 and `psw_oe` is 0, so the switch line is released.
- R2: One clock edge after `drv_int`=1 and `drv_ext`=0 are sampled, `pump_en` is 1 and `psw_oe` is 0.
- R3: One clock edge after `drv_ext`=1 is sampled, `psw_oe` is 1 and `pump_en` is 0, whatever the value of `drv_int`.
- R4: The fault line is watched only while `ind_use` and `ind_pass` are both 1. While either bit is 0, changes on `fault_in` never raise `evt_req`.
- R5: While watching, `vbus_vld` equals the level of `fault_in` from two clock edges earlier, after a two-flop synchronizer.
- R6: While not watching, `vbus_vld` equals `cmp_vld`.
- R7: While watching, a change on `fault_in` raises `evt_req` on the third clock edge after the change. At that point `evt_val` holds the new level.
- R8: `evt_req` stays at 1 until `evt_ack` is sampled at 1 while the request is pending. After that edge `evt_req` is 0, unless a new change was detected on the same edge.
- R9: If the watched level changes again before the acknowledge arrives, the request stays pending and `evt_val` holds only the newest level.
- R10: Synchronous active-high `rst` sets `pump_en`, `psw_oe` and `evt_req` to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_int | input | 1 | Register bit requesting the internal charge pump |
| drv_ext | input | 1 | Register bit requesting the external supply; overrides drv_int |
| ind_use | input | 1 | Register bit selecting the external VBUS indicator |
| ind_pass | input | 1 | Interface bit passing the indicator through unqualified |
| fault_in | input | 1 | Asynchronous digital fault line from the supervisor |
| cmp_vld | input | 1 | Internal VBUS-valid comparator output |
| evt_ack | input | 1 | Bus side has taken the pending status event |
| pump_en | output | 1 | Charge-pump enable |
| psw_oe | output | 1 | Pull-low enable for the open-drain external switch line |
| vbus_vld | output | 1 | Current VBUS-valid status bit |
| evt_req | output | 1 | Status event pending |
| evt_val | output | 1 | VBUS-valid level carried by the pending event |

## Verification
The assertions assume that the register bits change only between clock edges. They also assume that `evt_ack` is raised only while a request is pending, and that the fault line stays low while reset is active. If the line were high then, the synchronizer would show a change when reset is released. The bench meets these assumptions by driving every input on the falling edge. It holds `fault_in` low through reset, and it pulses `evt_ack` only after it has seen `evt_req` high. It leaves every fault change stable for at least three edges before it checks the result, except in the scenario that stacks two changes in front of one acknowledge.

// File: rtl/vbus_pwr_ctl.sv
module vbus_pwr_ctl (
  input  logic clk,
  input  logic rst,
  input  logic drv_int,
  input  logic drv_ext,
  input  logic ind_use,
  input  logic ind_pass,
  input  logic fault_in,
  input  logic cmp_vld,
  input  logic evt_ack,
  output logic pump_en,
  output logic psw_oe,
  output logic vbus_vld,
  output logic evt_req,
  output logic evt_val
);

  logic sync_a, sync_b, sync_d;
  logic watch, chg;

  assign watch    = ind_use & ind_pass;
  assign chg      = watch & (sync_b ^ sync_d);
  assign vbus_vld = watch ? sync_b : cmp_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_en <= 1'b0;
      psw_oe  <= 1'b0;
    end else begin
      pump_en <= drv_int & ~drv_ext;
      psw_oe  <= drv_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync_a <= fault_in;
      sync_b <= sync_a;
      sync_d <= sync_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_req <= 1'b0;
      evt_val <= 1'b0;
    end else if (chg) begin
      evt_req <= 1'b1;
      evt_val <= sync_b;
    end else if (evt_ack) begin
      evt_req <= 1'b0;
    end
  end

endmodule

// File: rtl/vbus_pwr_ctl_chk.sv
module vbus_pwr_ctl_chk (
  input logic clk,
  input logic rst,
  input logic drv_int,
  input logic drv_ext,
  input logic ind_use,
  input logic ind_pass,
  input logic evt_ack,
  input logic pump_en,
  input logic psw_oe,
  input logic evt_req
);

  // R1
  off_chk: assert property (@(posedge clk) disable iff (rst)
    (!drv_int && !drv_ext) |=> (!pump_en && !psw_oe));

  // R2
  pump_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_int && !drv_ext) |=> (pump_en && !psw_oe));

  // R3
  ext_chk: assert property (@(posedge clk) disable iff (rst)
    drv_ext |=> (psw_oe && !pump_en));

  // R4
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!(ind_use && ind_pass) && !evt_req) |=> !evt_req);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_req && !evt_ack) |=> evt_req);

  // R10
  rst_chk: assert property (@(posedge clk)
    rst |=> (!pump_en && !psw_oe && !evt_req));

endmodule

bind vbus_pwr_ctl vbus_pwr_ctl_chk u_chk (
  .clk(clk), .rst(rst), .drv_int(drv_int), .drv_ext(drv_ext),
  .ind_use(ind_use), .ind_pass(ind_pass), .evt_ack(evt_ack),
  .pump_en(pump_en), .psw_oe(psw_oe), .evt_req(evt_req)
);

// File: tb/vbus_pwr_ctl_test.sv
module vbus_pwr_ctl_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drv_int = 1'b0, drv_ext = 1'b0, ind_use = 1'b0, ind_pass = 1'b0;
  logic fault_in = 1'b0, cmp_vld = 1'b0, evt_ack = 1'b0;
  logic pump_en, psw_oe, vbus_vld, evt_req, evt_val;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbus_pwr_ctl uut (
    .clk(clk), .rst(rst), .drv_int(drv_int), .drv_ext(drv_ext),
    .ind_use(ind_use), .ind_pass(ind_pass), .fault_in(fault_in),
    .cmp_vld(cmp_vld), .evt_ack(evt_ack), .pump_en(pump_en),
    .psw_oe(psw_oe), .vbus_vld(vbus_vld), .evt_req(evt_req), .evt_val(evt_val)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ack();
    evt_ack = 1'b1;
    wait_neg(1);
    evt_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 pump", pump_en, 1'b0);
    check("R10 psw", psw_oe, 1'b0);
    check("R10 req", evt_req, 1'b0);
  endtask

  task automatic t_supply();
    drv_int = 1'b0; drv_ext = 1'b0; wait_neg(1);
    check("R1 pump", pump_en, 1'b0);
    check("R1 psw", psw_oe, 1'b0);
    drv_int = 1'b1; wait_neg(1);
    check("R2 pump", pump_en, 1'b1);
    check("R2 psw", psw_oe, 1'b0);
    drv_ext = 1'b1; wait_neg(1);
    check("R3 pump both", pump_en, 1'b0);
    check("R3 psw both", psw_oe, 1'b1);
    drv_int = 1'b0; wait_neg(1);
    check("R3 pump ext", pump_en, 1'b0);
    check("R3 psw ext", psw_oe, 1'b1);
    drv_ext = 1'b0; wait_neg(1);
    check("R1 psw release", psw_oe, 1'b0);
  endtask

  task automatic t_unwatched();
    ind_use = 1'b1; ind_pass = 1'b0; cmp_vld = 1'b1;
    fault_in = 1'b1; wait_neg(4);
    check("R4 half enable", evt_req, 1'b0);
    check("R6 cmp high", vbus_vld, 1'b1);
    ind_use = 1'b0; ind_pass = 1'b1; cmp_vld = 1'b0;
    fault_in = 1'b0; wait_neg(4);
    check("R4 other half", evt_req, 1'b0);
    check("R6 cmp low", vbus_vld, 1'b0);
  endtask

  task automatic t_rise_ack();
    ind_use = 1'b1; ind_pass = 1'b1; cmp_vld = 1'b1;
    wait_neg(2);
    check("R5 low", vbus_vld, 1'b0);
    fault_in = 1'b1;
    wait_neg(2);
    check("R5 high", vbus_vld, 1'b1);
    check("R7 not yet", evt_req, 1'b0);
    wait_neg(1);
    check("R7 req", evt_req, 1'b1);
    check("R7 val", evt_val, 1'b1);
    wait_neg(5);
    check("R8 held", evt_req, 1'b1);
    do_ack();
    check("R8 cleared", evt_req, 1'b0);
  endtask

  task automatic t_fall();
    fault_in = 1'b0; wait_neg(3);
    check("R7 fall req", evt_req, 1'b1);
    check("R7 fall val", evt_val, 1'b0);
    do_ack();
    check("R8 fall cleared", evt_req, 1'b0);
  endtask

  task automatic t_newest();
    fault_in = 1'b1; wait_neg(4);
    fault_in = 1'b0; wait_neg(4);
    check("R9 pending", evt_req, 1'b1);
    check("R9 newest", evt_val, 1'b0);
    do_ack();
    check("R9 single ack", evt_req, 1'b0);
  endtask

  task automatic t_reset_pending();
    fault_in = 1'b1; drv_int = 1'b1; drv_ext = 1'b1; wait_neg(4);
    check("R10 pre", evt_req, 1'b1);
    fault_in = 1'b0; rst = 1'b1; wait_neg(1);
    check("R10 clr req", evt_req, 1'b0);
    check("R10 clr psw", psw_oe, 1'b0);
    check("R10 clr pump", pump_en, 1'b0);
    rst = 1'b0; drv_int = 1'b0; drv_ext = 1'b0;
  endtask

  initial begin
    wait_neg(3);
    t_reset();
    rst = 1'b0;
    wait_neg(1);
    t_supply();
    t_unwatched();
    t_rise_ack();
    t_fall();
    t_newest();
    t_reset_pending();
    wait_neg(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule